// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block decides when an SDRAM controller must run an auto-refresh. It counts controller clock cycles and raises a refresh request each time a programmed interval expires. The interval is chosen by a 2-bit rate code, and one code turns refresh off. A static 2-bit clock select tells the block which bus frequency the controller runs at, so the cycle count for each interval gives the same absolute time at every supported frequency.

The request is level-based. It stays high until the command sequencer returns a one-cycle acknowledge. Intervals that expire while earlier requests are still outstanding are counted in a small saturating pending counter, so the sequencer can catch up on refreshes it deferred. Any change of the rate code or clock select restarts the interval count at once. Selecting the disabled code discards all outstanding requests.

Top module: `sdram_refresh_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `refresh_req` is low and `pend_count` is 0.
- R2: With `rate_code` 00, no request is produced. On the first clock edge that samples 00, `pend_count` is cleared to 0.
- R3: The interval in cycles is floor(ns × kHz / 1,000,000). The interval is 7800 ns for code 01, 15600 ns for code 10 and 125000 ns for code 11. The frequency is 66666 kHz for select 00, 100000 kHz for select 01 and 133333 kHz for select 10. Select 11 behaves as select 10. While the setting is unchanged, expirations are exactly this many cycles apart.
- R4: When `rate_code` or `clk_sel` changes, the count restarts. The first expiration happens on the interval-th clock edge after the edge that first samples the new setting.
- R5: `refresh_req` is high whenever `pend_count` is nonzero. An `refresh_ack` pulse with no expiration in the same cycle lowers `pend_count` by one.
- R6: An expiration with no acknowledge raises `pend_count` by one, up to a limit of 8. An expiration at 8 leaves it at 8.
- R7: An acknowledge and an expiration in the same cycle leave a nonzero `pend_count` unchanged.
- R8: An acknowledge while `pend_count` is 0 has no effect. The next expiration still brings the count to exactly 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_code | input | 2 | Refresh rate select: 00 off, 01 short, 10 medium, 11 long |
| clk_sel | input | 2 | Bus frequency select: 00 66 MHz, 01 100 MHz, 10/11 133 MHz |
| refresh_ack | input | 1 | One-cycle acknowledge from the command sequencer |
| refresh_req | output | 1 | Refresh request, high while any request is outstanding |
| pend_count | output | 4 | Number of outstanding requests (0 to 8) |

## Verification
The bench sweeps all three active rate codes against all four clock selects. For each pair it measures the delay from the setting change to the first request and the spacing to the second request. The first measurement separates the restart behaviour from the steady period. The second catches a wrong table entry or an off-by-one at the terminal count. A run with no acknowledges fills the pending counter past its limit and shows that it saturates. An acknowledge timed to land on an expiration separates the simultaneous case from a plain decrement. Acknowledges with nothing pending, a long run at the disabled code, and a switch to the disabled code while requests are outstanding cover the cases where input must have no effect or must clear state.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef enum logic [1:0] {
    RATE_OFF   = 2'b00,
    RATE_SHORT = 2'b01,
    RATE_MID   = 2'b10,
    RATE_LONG  = 2'b11
  } rate_e;

  // Whole cycles in an interval of ns nanoseconds at khz kilohertz, rounded down.
  function automatic int unsigned cycles_for(input int unsigned ns, input int unsigned khz);
    longint unsigned prod;
    prod = 64'(ns) * 64'(khz);
    return 32'(prod / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/refresh_rate_decode.sv
module refresh_rate_decode
  import sdram_refresh_pkg::*;
#(
  parameter int unsigned FREQ0_KHZ = 66666,
  parameter int unsigned FREQ1_KHZ = 100000,
  parameter int unsigned FREQ2_KHZ = 133333,
  parameter int unsigned SHORT_NS  = 7800,
  parameter int unsigned MID_NS    = 15600,
  parameter int unsigned LONG_NS   = 125000,
  parameter int unsigned CNT_W     = 15
) (
  input  logic [1:0]       rate_code,
  input  logic [1:0]       clk_sel,
  output logic [CNT_W-1:0] term_cnt,
  output logic             enable
);

  localparam int unsigned TC_S0 = cycles_for(SHORT_NS, FREQ0_KHZ);
  localparam int unsigned TC_S1 = cycles_for(SHORT_NS, FREQ1_KHZ);
  localparam int unsigned TC_S2 = cycles_for(SHORT_NS, FREQ2_KHZ);
  localparam int unsigned TC_M0 = cycles_for(MID_NS, FREQ0_KHZ);
  localparam int unsigned TC_M1 = cycles_for(MID_NS, FREQ1_KHZ);
  localparam int unsigned TC_M2 = cycles_for(MID_NS, FREQ2_KHZ);
  localparam int unsigned TC_L0 = cycles_for(LONG_NS, FREQ0_KHZ);
  localparam int unsigned TC_L1 = cycles_for(LONG_NS, FREQ1_KHZ);
  localparam int unsigned TC_L2 = cycles_for(LONG_NS, FREQ2_KHZ);

  always_comb begin
    enable   = (rate_e'(rate_code) != RATE_OFF);
    term_cnt = '0;
    unique case (rate_e'(rate_code))
      RATE_SHORT: begin
        case (clk_sel)
          2'b00:   term_cnt = CNT_W'(TC_S0);
          2'b01:   term_cnt = CNT_W'(TC_S1);
          default: term_cnt = CNT_W'(TC_S2);
        endcase
      end
      RATE_MID: begin
        case (clk_sel)
          2'b00:   term_cnt = CNT_W'(TC_M0);
          2'b01:   term_cnt = CNT_W'(TC_M1);
          default: term_cnt = CNT_W'(TC_M2);
        endcase
      end
      RATE_LONG: begin
        case (clk_sel)
          2'b00:   term_cnt = CNT_W'(TC_L0);
          2'b01:   term_cnt = CNT_W'(TC_L1);
          default: term_cnt = CNT_W'(TC_L2);
        endcase
      end
      default: term_cnt = '0;
    endcase
  end

endmodule

// File: rtl/refresh_interval_counter.sv
module refresh_interval_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_code,
  input  logic [1:0]       clk_sel,
  input  logic             enable,
  input  logic [CNT_W-1:0] term_cnt,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       cfg_q, cfg_d;
  logic             cfg_change;

  assign cfg_d      = {rate_code, clk_sel};
  assign cfg_change = (cfg_d != cfg_q);

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (!enable || cfg_change) begin
      cnt_d = '0;
    end else if (cnt_q >= term_cnt - 1'b1) begin
      cnt_d  = '0;
      expire = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cfg_q <= cfg_d;
    end
  end

  // R3
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));

  // R4
  cfg_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({rate_code, clk_sel} != cfg_q) |=> (cnt_q == '0));

endmodule

// File: rtl/refresh_pending_tracker.sv
module refresh_pending_tracker #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              expire,
  input  logic              ack,
  output logic              req,
  output logic [PEND_W-1:0] pend
);

  localparam logic [PEND_W-1:0] LIMIT = PEND_W'(PEND_MAX);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic              has_pend;

  assign has_pend = (pend_q != '0);

  always_comb begin
    pend_d = pend_q;
    if (!enable) begin
      pend_d = '0;
    end else if (expire && !(ack && has_pend)) begin
      if (pend_q < LIMIT) pend_d = pend_q + 1'b1;
    end else if (!expire && ack && has_pend) begin
      pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign req  = has_pend;
  assign pend = pend_q;

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= LIMIT);

  // R2
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pend_q == '0));

  // R5
  ack_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ack && !expire && pend_q != '0) |=> (pend_q == $past(pend_q) - 1'b1));

  // R7
  ack_meets_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ack && expire && pend_q != '0) |=> $stable(pend_q));

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer
  import sdram_refresh_pkg::*;
#(
  parameter int unsigned FREQ0_KHZ = 66666,
  parameter int unsigned FREQ1_KHZ = 100000,
  parameter int unsigned FREQ2_KHZ = 133333,
  parameter int unsigned SHORT_NS  = 7800,
  parameter int unsigned MID_NS    = 15600,
  parameter int unsigned LONG_NS   = 125000,
  parameter int unsigned PEND_MAX  = 8,
  localparam int unsigned PEND_W   = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_code,
  input  logic [1:0]        clk_sel,
  input  logic              refresh_ack,
  output logic              refresh_req,
  output logic [PEND_W-1:0] pend_count
);

  localparam int unsigned MAX_F01 = (FREQ0_KHZ > FREQ1_KHZ) ? FREQ0_KHZ : FREQ1_KHZ;
  localparam int unsigned MAX_F   = (MAX_F01 > FREQ2_KHZ) ? MAX_F01 : FREQ2_KHZ;
  localparam int unsigned MAX_NS01 = (SHORT_NS > MID_NS) ? SHORT_NS : MID_NS;
  localparam int unsigned MAX_NS   = (MAX_NS01 > LONG_NS) ? MAX_NS01 : LONG_NS;
  localparam int unsigned MAX_TC   = cycles_for(MAX_NS, MAX_F);
  localparam int unsigned CNT_W    = $clog2(MAX_TC + 1);

  logic [CNT_W-1:0] term_cnt;
  logic             enable;
  logic             expire;

  refresh_rate_decode #(
    .FREQ0_KHZ(FREQ0_KHZ), .FREQ1_KHZ(FREQ1_KHZ), .FREQ2_KHZ(FREQ2_KHZ),
    .SHORT_NS(SHORT_NS), .MID_NS(MID_NS), .LONG_NS(LONG_NS), .CNT_W(CNT_W)
  ) u_decode (
    .rate_code(rate_code),
    .clk_sel  (clk_sel),
    .term_cnt (term_cnt),
    .enable   (enable)
  );

  refresh_interval_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_code(rate_code),
    .clk_sel  (clk_sel),
    .enable   (enable),
    .term_cnt (term_cnt),
    .expire   (expire)
  );

  refresh_pending_tracker #(.PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) u_pending (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(enable),
    .expire(expire),
    .ack   (refresh_ack),
    .req   (refresh_req),
    .pend  (pend_count)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) $fell(rst_n) |=> (!refresh_req && pend_count == '0));

endmodule

// File: tb/sdram_refresh_timer_tb.sv
module sdram_refresh_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rate_code;
  logic [1:0] clk_sel;
  logic       refresh_ack;
  logic       refresh_req;
  logic [3:0] pend_count;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  sdram_refresh_timer u_dut (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .clk_sel(clk_sel),
    .refresh_ack(refresh_ack), .refresh_req(refresh_req), .pend_count(pend_count)
  );

  function automatic int exp_tc(input logic [1:0] rc, input logic [1:0] cs);
    longint ns, khz;
    case (rc)
      2'b01:   ns = 7800;
      2'b10:   ns = 15600;
      default: ns = 125000;
    endcase
    case (cs)
      2'b00:   khz = 66666;
      2'b01:   khz = 100000;
      default: khz = 133333;
    endcase
    return int'((ns * khz) / 1000000);
  endfunction

  task automatic check(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(inout int n);
    @(posedge clk); @(negedge clk); n++;
  endtask

  task automatic clear_off();
    rate_code = 2'b00;
    @(posedge clk); @(negedge clk);
    check("R2 cleared on off", pend_count, 0);
  endtask

  task automatic wait_req(inout int n);
    while (!refresh_req && n < 40000) tick(n);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 199000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 199000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int n;
    int tc;
    bit seen;
    rst_n = 1'b0; rate_code = 2'b01; clk_sel = 2'b00; refresh_ack = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 req in reset", refresh_req, 0);
    check("R1 pend in reset", pend_count, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 req after release", refresh_req, 0);
    check("R1 pend after release", pend_count, 0);

    // R3 / R4 sweep over every rate and clock select
    for (int rc = 1; rc < 4; rc++) begin
      for (int cs = 0; cs < 4; cs++) begin
        clear_off();
        clk_sel = 2'(cs);
        rate_code = 2'(rc);
        tc = exp_tc(2'(rc), 2'(cs));
        n = 0;
        wait_req(n);
        check($sformatf("R4 first expiry rc=%0d cs=%0d", rc, cs), n, tc + 1);
        refresh_ack = 1'b1;
        tick(n);
        refresh_ack = 1'b0;
        check("R5 ack drops req", refresh_req, 0);
        wait_req(n);
        check($sformatf("R3 period rc=%0d cs=%0d", rc, cs), n, 2 * tc + 1);
      end
    end

    // R8: ack with nothing pending, then pending build-up
    clear_off();
    refresh_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    refresh_ack = 1'b0;
    check("R8 ack while off", pend_count, 0);
    clk_sel = 2'b00;
    rate_code = 2'b01;
    tc = exp_tc(2'b01, 2'b00);
    n = 0;
    tick(n);
    refresh_ack = 1'b1;
    tick(n);
    refresh_ack = 1'b0;
    check("R8 ack with none pending", pend_count, 0);
    wait_req(n);
    check("R8 first expiry timing", n, tc + 1);
    check("R8 count after expiry", pend_count, 1);

    // R7: ack lands on the next expiration
    while (n < 2 * tc) tick(n);
    refresh_ack = 1'b1;
    tick(n);
    refresh_ack = 1'b0;
    check("R7 ack on expiry keeps count", pend_count, 1);

    // R6: fill and saturate
    for (int k = 2; k <= 9; k++) begin
      repeat (tc) tick(n);
      check($sformatf("R6 count after %0d expiries", k), pend_count, (k > 8) ? 8 : k);
    end
    check("R5 req with pending", refresh_req, 1);

    refresh_ack = 1'b1;
    tick(n);
    refresh_ack = 1'b0;
    check("R5 single decrement", pend_count, 7);

    // R2: switch to off with requests outstanding, then stay off
    rate_code = 2'b00;
    @(posedge clk); @(negedge clk);
    check("R2 off clears pending", pend_count, 0);
    check("R2 off drops req", refresh_req, 0);
    seen = 1'b0;
    for (int i = 0; i < 17000; i++) begin
      @(posedge clk); @(negedge clk);
      if (refresh_req) seen = 1'b1;
    end
    check("R2 no request while off", seen, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule